// File: doc/BRIEF.md
# Accumulator CPU Core

A small multi-cycle processor built around an 8-bit accumulator A, one general register B, a 16-bit pointer pair HL (H is the upper byte) and two flags: carry and zero. It fetches and executes a reduced instruction set over a byte-wide memory port with 16-bit addresses. The port makes one access per clock. Instructions cover loading HL, loading A and B, stepping HL, adding and storing through HL, a right rotate of A through carry, a countdown on B with a conditional jump, and halt.

The memory port is a plain synchronous-write, combinational-read interface. The core places an address each cycle and samples `mem_rdata` at the next rising edge. A write happens in any cycle with `mem_we` high. The port has no valid/ready pair and no back-pressure: memory must answer within the same cycle and accept every write. Multi-byte operands follow the opcode with the low byte first. After reset the core starts fetching at address 0x0000. It runs until it executes a halt, then raises `halted` and stays there until the next reset. An unlisted opcode takes two cycles and changes nothing.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_addr` is 0x0000, `mem_we` is 0 and `halted` is 0. A, B, HL, carry and zero all start at zero.
- R2: Opcode 0x01 followed by bytes lo, hi loads HL with {hi, lo}, so H gets the second operand byte.
- R3: Opcode 0x03 adds one to the full 16-bit HL, carrying from L into H (0x12FF becomes 0x1300).
- R4: Opcode 0x04 reads the byte at address HL and adds it to A. A keeps the low 8 bits of the sum, and carry takes bit 8 of the sum.
- R5: Opcode 0x05 writes A to address HL, with `mem_we` high for exactly one cycle and `mem_wdata` equal to A.
- R6: Opcode 0x06 followed by bytes lo, hi (address N) sets L from memory[N] and H from memory[N+1].
- R7: Opcode 0x07 replaces A with {carry, A[7:1]} and sets carry to the old A[0].
- R8: Opcode 0x02 followed by one byte loads A with it, and opcode 0x0A followed by one byte loads B with it.
- R9: Opcode 0x08 subtracts one from B (modulo 256) and sets zero exactly when the result is 0x00. Opcode 0x09 followed by bytes lo, hi jumps to {hi, lo} when zero is clear and otherwise continues with the next instruction.
- R10: Opcode 0x0F stops fetching. `halted` goes high and stays high, `mem_we` stays low and `mem_addr` holds still until reset.
- R11: Cycle counts per instruction: two for opcodes with no operand, two for 0x02/0x0A, three for 0x01 and 0x09, and five for 0x06. Halt raises `halted` one cycle after its opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Address of this cycle's memory access |
| mem_wdata | output | 8 | Byte to write (the accumulator) |
| mem_rdata | input | 8 | Byte read from `mem_addr`, valid in the same cycle |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| halted | output | 1 | High once a halt has executed |

## Verification
No register is visible at the ports, so a wrong accumulator, pointer or flag value only shows when a store writes it out. A bad carry appears at the store after the next rotate. A bad pointer appears as a wrong store address. A bad zero flag appears as a wrong number of loop writes or a missing write. Sequencing faults appear sooner, as a shifted halt cycle or a write strobe that is longer than one cycle or arrives at the wrong time. Each program is therefore written so that every state it changes reaches memory within a few instructions.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_OPR1,
    ST_OPR2,
    ST_EXEC,
    ST_MEM,
    ST_MEM2,
    ST_HALT
  } cpu_state_e;

  localparam logic [7:0] OPC_HL_IMM  = 8'h01;
  localparam logic [7:0] OPC_A_IMM   = 8'h02;
  localparam logic [7:0] OPC_HL_INC  = 8'h03;
  localparam logic [7:0] OPC_ADD_MEM = 8'h04;
  localparam logic [7:0] OPC_ST_MEM  = 8'h05;
  localparam logic [7:0] OPC_HL_DIR  = 8'h06;
  localparam logic [7:0] OPC_ROT_R   = 8'h07;
  localparam logic [7:0] OPC_B_DEC   = 8'h08;
  localparam logic [7:0] OPC_JMP_NZ  = 8'h09;
  localparam logic [7:0] OPC_B_IMM   = 8'h0A;
  localparam logic [7:0] OPC_STOP    = 8'h0F;

  typedef struct packed {
    logic [1:0] n_opr;     // operand bytes after the opcode
    logic       to_mem;    // needs a data access through a pointer
    logic       mem_pair;  // data access spans two bytes
    logic       stop;      // enter the halted state
  } op_info_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [7:0] opcode,
  output op_info_t   info
);

  always_comb begin
    info = '0;
    case (opcode)
      OPC_HL_IMM, OPC_JMP_NZ: info.n_opr = 2'd2;
      OPC_A_IMM, OPC_B_IMM:   info.n_opr = 2'd1;
      OPC_ADD_MEM, OPC_ST_MEM: info.to_mem = 1'b1;
      OPC_HL_DIR: begin
        info.n_opr    = 2'd2;
        info.to_mem   = 1'b1;
        info.mem_pair = 1'b1;
      end
      OPC_STOP: info.stop = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] breg,
  input  logic              cy,
  input  logic [DATA_W-1:0] mbyte,
  output logic [DATA_W-1:0] sum,
  output logic              sum_cy,
  output logic [DATA_W-1:0] rot,
  output logic              rot_cy,
  output logic [DATA_W-1:0] bdec,
  output logic              bdec_zero
);

  logic [DATA_W:0] wide_sum;

  always_comb begin
    wide_sum  = {1'b0, acc} + {1'b0, mbyte};
    sum       = wide_sum[DATA_W-1:0];
    sum_cy    = wide_sum[DATA_W];
    rot       = {cy, acc[DATA_W-1:1]};
    rot_cy    = acc[0];
    bdec      = breg - 1'b1;
    bdec_zero = (bdec == '0);
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_info_t   info,
  output cpu_state_e state
);

  cpu_state_e nxt;

  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH: begin
        if (info.n_opr != 2'd0) nxt = ST_OPR1;
        else if (info.to_mem)   nxt = ST_MEM;
        else if (info.stop)     nxt = ST_HALT;
        else                    nxt = ST_EXEC;
      end
      ST_OPR1: nxt = (info.n_opr == 2'd2) ? ST_OPR2 : ST_FETCH;
      ST_OPR2: nxt = info.to_mem ? ST_MEM : ST_FETCH;
      ST_MEM:  nxt = info.mem_pair ? ST_MEM2 : ST_FETCH;
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nxt;
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  mem_we,
  output logic                  halted
);

  localparam int ADDR_W = 2 * DATA_W;

  cpu_state_e          state;
  op_info_t            info;
  logic [7:0]          ir;
  logic [7:0]          opc_now;
  logic [ADDR_W-1:0]   pc;
  logic [ADDR_W-1:0]   hl;
  logic [DATA_W-1:0]   acc, breg, opr_lo, opr_hi;
  logic                cy, zf;
  logic [ADDR_W-1:0]   ptr;
  logic [DATA_W-1:0]   sum, rot, bdec;
  logic                sum_cy, rot_cy, bdec_zero;

  // The opcode is decoded straight off the bus while it is fetched.
  assign opc_now = (state == ST_FETCH) ? mem_rdata[7:0] : ir;
  assign ptr     = {opr_hi, opr_lo};

  acc_cpu_decode u_dec (
    .opcode (opc_now),
    .info   (info)
  );

  acc_cpu_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .info  (info),
    .state (state)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .acc       (acc),
    .breg      (breg),
    .cy        (cy),
    .mbyte     (mem_rdata),
    .sum       (sum),
    .sum_cy    (sum_cy),
    .rot       (rot),
    .rot_cy    (rot_cy),
    .bdec      (bdec),
    .bdec_zero (bdec_zero)
  );

  always_comb begin
    case (state)
      ST_MEM:  mem_addr = (ir == OPC_HL_DIR) ? ptr : hl;
      ST_MEM2: mem_addr = ptr + 1'b1;
      default: mem_addr = pc;
    endcase
  end

  assign mem_we    = (state == ST_MEM) && (ir == OPC_ST_MEM);
  assign mem_wdata = acc;
  assign halted    = (state == ST_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      hl     <= '0;
      acc    <= '0;
      breg   <= '0;
      opr_lo <= '0;
      opr_hi <= '0;
      ir     <= '0;
      cy     <= 1'b0;
      zf     <= 1'b0;
    end else begin
      case (state)
        ST_FETCH: begin
          ir <= mem_rdata[7:0];
          pc <= pc + 1'b1;
        end
        ST_OPR1: begin
          pc <= pc + 1'b1;
          case (ir)
            OPC_A_IMM: acc    <= mem_rdata;
            OPC_B_IMM: breg   <= mem_rdata;
            default:   opr_lo <= mem_rdata;
          endcase
        end
        ST_OPR2: begin
          case (ir)
            OPC_HL_IMM: begin
              hl <= {mem_rdata, opr_lo};
              pc <= pc + 1'b1;
            end
            OPC_JMP_NZ: pc <= zf ? pc + 1'b1 : {mem_rdata, opr_lo};
            default: begin
              opr_hi <= mem_rdata;
              pc     <= pc + 1'b1;
            end
          endcase
        end
        ST_MEM: begin
          case (ir)
            OPC_ADD_MEM: begin
              acc <= sum;
              cy  <= sum_cy;
            end
            OPC_HL_DIR: hl[DATA_W-1:0] <= mem_rdata;
            default: ;
          endcase
        end
        ST_MEM2: hl[ADDR_W-1:DATA_W] <= mem_rdata;
        ST_EXEC: begin
          case (ir)
            OPC_HL_INC: hl <= hl + 1'b1;
            OPC_ROT_R: begin
              acc <= rot;
              cy  <= rot_cy;
            end
            OPC_B_DEC: begin
              breg <= bdec;
              zf   <= bdec_zero;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          halted
);

  // R1: first cycle out of reset fetches from address zero with no write
  a_r1_start_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == '0 && !mem_we && !halted));

  // R10: halted never drops without reset
  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R10: no write strobe while halted
  a_r10_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);

  // R10: address frozen while halted
  a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr));

  // R5: a store strobe lasts a single cycle
  a_r5_store_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

endmodule

bind acc_cpu acc_cpu_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_addr (mem_addr),
  .mem_we   (mem_we),
  .halted   (halted)
);

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_we;
  logic        halted;

  logic [7:0] mem [0:65535];

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct {
    logic [15:0] a;
    logic [7:0]  d;
    string       tag;
  } wr_t;

  wr_t exp_q[$];

  always #5 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst && mem_we) mem[mem_addr] <= mem_wdata;
  end

  // Monitor: pops one expected write per observed strobe.
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected write: actual %h<=%h expected none", mem_addr, mem_wdata);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        if (mem_addr !== e.a || mem_wdata !== e.d) begin
          fails++;
          $display("FAIL %s write: actual %h<=%h expected %h<=%h",
                   e.tag, mem_addr, mem_wdata, e.a, e.d);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    mem[a] = d;
  endtask

  task automatic expect_wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    wr_t e;
    e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Holds reset, clears memory and checks the reset outputs (R1).
  task automatic prep();
    rst = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 65536; i++) mem[i] = 8'h00;
    check(mem_addr == 16'h0000 && !mem_we && !halted,
          $sformatf("R1 reset outputs: actual addr=%h we=%b halted=%b expected 0000/0/0",
                    mem_addr, mem_we, halted));
  endtask

  task automatic run(input int exp_cycles, input string tag);
    int n = 0;
    logic [15:0] a0;
    bit still;
    rst = 1'b0;
    do begin
      @(negedge clk);
      n++;
    end while (!halted && n < 600);
    check(halted === 1'b1, $sformatf("%s R10 halt reached: actual %b expected 1", tag, halted));
    if (exp_cycles > 0)
      check(n == exp_cycles, $sformatf("%s R11 cycles to halt: actual %0d expected %0d",
                                       tag, n, exp_cycles));
    a0 = mem_addr;
    still = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (!halted || mem_we || mem_addr !== a0) still = 1'b0;
    end
    check(still, $sformatf("%s R10 halted quiet: actual addr=%h halted=%b expected addr=%h halted=1",
                           tag, mem_addr, halted, a0));
    check(exp_q.size() == 0, $sformatf("%s missing writes: actual %0d left expected 0",
                                       tag, exp_q.size()));
  endtask

  initial begin
    // P1: R2 R3 R4 R5 R8 pointer add and store, R11 cycle count
    prep();
    put(0, 8'h01); put(1, 8'h01); put(2, 8'h20);
    put(3, 8'h02); put(4, 8'h21);
    put(5, 8'h03); put(6, 8'h04); put(7, 8'h03); put(8, 8'h05); put(9, 8'h0F);
    put(16'h2002, 8'hB1);
    expect_wr(16'h2003, 8'hD2, "R4");
    run(14, "P1");

    // P2: R4 carry from add, R7 rotate brings it in; leaves carry set
    prep();
    put(0, 8'h02); put(1, 8'hF0);
    put(2, 8'h01); put(3, 8'h00); put(4, 8'h40);
    put(5, 8'h04); put(6, 8'h05); put(7, 8'h07); put(8, 8'h05);
    put(9, 8'h04); put(10, 8'h0F);
    put(16'h4000, 8'h20);
    expect_wr(16'h4000, 8'h10, "R4");
    expect_wr(16'h4000, 8'h88, "R7");
    run(0, "P2");

    // P3: R1 registers and carry cleared by reset (rotate of A=0, C=0)
    prep();
    put(0, 8'h07); put(1, 8'h05); put(2, 8'h0F);
    expect_wr(16'h0000, 8'h00, "R1");
    run(0, "P3");

    // P4: R9 countdown loop, R7 rotations, R8 load of B
    prep();
    put(0, 8'h02); put(1, 8'h03); put(2, 8'h0A); put(3, 8'h04);
    put(4, 8'h01); put(5, 8'h00); put(6, 8'h50);
    put(7, 8'h07); put(8, 8'h05); put(9, 8'h03); put(10, 8'h08);
    put(11, 8'h09); put(12, 8'h07); put(13, 8'h00); put(14, 8'h0F);
    expect_wr(16'h5000, 8'h01, "R9");
    expect_wr(16'h5001, 8'h80, "R9");
    expect_wr(16'h5002, 8'hC0, "R9");
    expect_wr(16'h5003, 8'h60, "R9");
    run(0, "P4");

    // P5: R6 direct pointer load, low byte first
    prep();
    put(0, 8'h06); put(1, 8'h00); put(2, 8'h30);
    put(3, 8'h02); put(4, 8'h5A); put(5, 8'h05); put(6, 8'h0F);
    put(16'h3000, 8'h34); put(16'h3001, 8'h12);
    expect_wr(16'h1234, 8'h5A, "R6");
    run(0, "P5");

    // P6: R3 increment carries from L into H
    prep();
    put(0, 8'h01); put(1, 8'hFF); put(2, 8'h12);
    put(3, 8'h03); put(4, 8'h02); put(5, 8'h77); put(6, 8'h05); put(7, 8'h0F);
    expect_wr(16'h1300, 8'h77, "R3");
    run(0, "P6");

    // P7: R9 decrement of B=0 wraps to FF, zero clear, jump taken
    prep();
    put(0, 8'h08); put(1, 8'h09); put(2, 8'h06); put(3, 8'h00);
    put(4, 8'h0F); put(5, 8'h0F);
    put(6, 8'h02); put(7, 8'hAB);
    put(8, 8'h01); put(9, 8'h00); put(10, 8'h70); put(11, 8'h05); put(12, 8'h0F);
    expect_wr(16'h7000, 8'hAB, "R9");
    run(0, "P7");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule